// File: doc/BRIEF.md
# Dual-Subsystem Reset Sequencer

This controller drives the reset lines of a device that holds two processor subsystems, a primary and a secondary. It takes an asynchronous power-on reset, the watchdog and NMI-watchdog expiry pulses of both subsystems, a reset-enable for each watchdog, a release strobe written by the primary and a write-one-to-clear strobe for the cause flags. It decides how far each fault reaches. A fault on the primary resets the whole device. A fault on the secondary resets the secondary alone.

Whenever the device leaves a device-wide reset, the secondary stays in reset until the primary releases it. A secondary-only reset ends by itself after a fixed pulse. If that reset came from the secondary's NMI watchdog, the primary receives a one-cycle NMI. Four sticky cause flags record which watchdog event caused a reset. Internal device-wide resets keep these flags, so boot software can read the cause after the reset.

Top module: `dual_reset_seq`

## Requirements
- R1: Driving `por_n` low forces `p_rst_n`, `s_rst_n` and all of `cause` to 0 at once, without waiting for a clock edge. After `por_n` rises, `p_rst_n` rises on the second rising clock edge, and `s_rst_n` stays low.
- R2: A primary watchdog expiry with `p_wd_rst_en` high starts a device-wide reset. Both resets are low for exactly PULSE_LEN (16) cycles and `cause[0]` is set. With `p_wd_rst_en` low, the expiry has no effect.
- R3: A primary NMI-watchdog expiry always starts the same device-wide reset of PULSE_LEN cycles and sets `cause[1]`.
- R4: A secondary NMI-watchdog expiry drives `s_rst_n` low for exactly PULSE_LEN cycles, leaves `p_rst_n` high and sets `cause[3]`.
- R5: When a secondary reset caused by its NMI watchdog ends, `sec_nmi` is high for one cycle, in the same cycle in which `s_rst_n` returns high. A secondary watchdog reset raises no NMI.
- R6: A secondary watchdog expiry resets only the secondary, for PULSE_LEN cycles, and sets `cause[2]`, but only while `s_wd_rst_en` is high. Otherwise it is ignored.
- R7: After any device-wide reset, `s_rst_n` stays low until a `rel_req` strobe arrives. It rises on the edge that samples that strobe.
- R8: After a secondary-only reset, `s_rst_n` returns high on its own, with no release strobe.
- R9: `rel_req` is ignored while a device-wide reset is active. It has no effect while the secondary is running.
- R10: `cause` bits are cleared only by `clr_we` with the matching `clr_mask` bits set (bit 0 primary WD, 1 primary NMIWD, 2 secondary WD, 3 secondary NMIWD), or by `por_n`. A new event wins over a clear in the same cycle. Internal device-wide resets keep the flags.
- R11: When primary and secondary faults arrive in the same cycle, the primary fault takes effect and the secondary fault is dropped. Secondary faults that arrive while the secondary is in reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on device reset, active low, asynchronous |
| p_wd_exp | input | 1 | Primary watchdog expiry pulse |
| p_nmiwd_exp | input | 1 | Primary NMI-watchdog expiry pulse |
| p_wd_rst_en | input | 1 | Primary watchdog may reset |
| s_wd_exp | input | 1 | Secondary watchdog expiry pulse |
| s_nmiwd_exp | input | 1 | Secondary NMI-watchdog expiry pulse |
| s_wd_rst_en | input | 1 | Secondary watchdog may reset |
| rel_req | input | 1 | Primary's request to release the secondary |
| clr_we | input | 1 | Cause-flag clear strobe |
| clr_mask | input | 4 | Flags to clear, one bit per flag |
| p_rst_n | output | 1 | Primary / device reset, active low |
| s_rst_n | output | 1 | Secondary reset, active low |
| sec_nmi | output | 1 | One-cycle NMI to the primary on the end of a secondary NMI-watchdog reset |
| cause | output | 4 | Sticky reset-cause flags |

## Verification
The bench builds the block with its default values: a pulse of 16 cycles and a two-stage synchronizer. The table therefore counts the real pulse edge by edge, checking the cycle before and the cycle on which each reset returns high. It covers both kinds of pulse. The same-cycle collisions are part of the table: a primary fault against a secondary fault, an event against a clear, and a release against an active device-wide reset. A power-on reset in the middle of the run shows that the flags clear without a clock edge and that the synchronizer releases the device two edges later.

// File: rtl/dual_reset_seq.sv
module dual_reset_seq #(
  parameter int PULSE_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       p_wd_exp,
  input  logic       p_nmiwd_exp,
  input  logic       p_wd_rst_en,
  input  logic       s_wd_exp,
  input  logic       s_nmiwd_exp,
  input  logic       s_wd_rst_en,
  input  logic       rel_req,
  input  logic       clr_we,
  input  logic [3:0] clr_mask,
  output logic       p_rst_n,
  output logic       s_rst_n,
  output logic       sec_nmi,
  output logic [3:0] cause
);
  localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

  logic [SYNC_STAGES-1:0] por_sync;
  logic          dev_act, sec_act, sec_hold, sec_src_nmi;
  logic [CW-1:0] dev_cnt, sec_cnt;
  logic          dev_rst, p_fault, s_fault;
  logic [3:0]    set_v;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) por_sync <= '0;
    else        por_sync <= {por_sync[SYNC_STAGES-2:0], 1'b1};

  assign dev_rst = ~por_sync[SYNC_STAGES-1] | dev_act;
  assign p_fault = ~dev_rst & (p_nmiwd_exp | (p_wd_exp & p_wd_rst_en));
  assign s_fault = ~dev_rst & ~p_fault & ~sec_hold & ~sec_act &
                   (s_nmiwd_exp | (s_wd_exp & s_wd_rst_en));
  assign set_v   = {s_fault & s_nmiwd_exp, s_fault & s_wd_exp & s_wd_rst_en,
                    p_fault & p_nmiwd_exp, p_fault & p_wd_exp & p_wd_rst_en};

  assign p_rst_n = ~dev_rst;
  assign s_rst_n = ~dev_rst & ~sec_hold & ~sec_act;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) cause <= '0;
    else        cause <= (cause & ~({4{clr_we}} & clr_mask)) | set_v;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      dev_act <= 1'b0;
      dev_cnt <= '0;
    end else if (p_fault) begin
      dev_act <= 1'b1;
      dev_cnt <= '0;
    end else if (dev_act) begin
      if (dev_cnt == LAST) dev_act <= 1'b0;
      else                 dev_cnt <= dev_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sec_hold    <= 1'b1;
      sec_act     <= 1'b0;
      sec_cnt     <= '0;
      sec_src_nmi <= 1'b0;
      sec_nmi     <= 1'b0;
    end else begin
      sec_nmi <= 1'b0;
      if (dev_rst | p_fault) begin
        sec_hold <= 1'b1;
        sec_act  <= 1'b0;
      end else if (s_fault) begin
        sec_act     <= 1'b1;
        sec_cnt     <= '0;
        sec_src_nmi <= s_nmiwd_exp;
      end else if (sec_act) begin
        if (sec_cnt == LAST) begin
          sec_act <= 1'b0;
          sec_nmi <= sec_src_nmi;
        end else begin
          sec_cnt <= sec_cnt + 1'b1;
        end
      end else if (rel_req && sec_hold) begin
        sec_hold <= 1'b0;
      end
    end

  // R7
  device_exit_holds_sec_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(p_rst_n) |-> !s_rst_n);
  // R5
  nmi_single_cycle_chk: assert property (@(posedge clk) disable iff (!por_n)
    sec_nmi |=> !sec_nmi);
  // R5
  nmi_with_sec_exit_chk: assert property (@(posedge clk) disable iff (!por_n)
    sec_nmi |-> $rose(s_rst_n));
  // R8
  sec_exit_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(s_rst_n) |-> ($past(rel_req) || $past(sec_act)));
  // R10
  flags_clear_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!por_n)
    ((~cause & $past(cause)) != 4'b0) |-> $past(clr_we));
  // R2
  sec_runs_under_primary_chk: assert property (@(posedge clk) disable iff (!por_n)
    s_rst_n |-> p_rst_n);
endmodule

// File: tb/sim_dual_reset_seq.sv
module sim_dual_reset_seq;
  logic clk = 1'b0;
  logic por_n;
  logic p_wd_exp, p_nmiwd_exp, p_wd_rst_en, s_wd_exp, s_nmiwd_exp, s_wd_rst_en;
  logic rel_req, clr_we;
  logic [3:0] clr_mask;
  logic p_rst_n, s_rst_n, sec_nmi;
  logic [3:0] cause;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  dual_reset_seq #(.PULSE_LEN(16), .SYNC_STAGES(2)) u0 (
    .clk(clk), .por_n(por_n), .p_wd_exp(p_wd_exp), .p_nmiwd_exp(p_nmiwd_exp),
    .p_wd_rst_en(p_wd_rst_en), .s_wd_exp(s_wd_exp), .s_nmiwd_exp(s_nmiwd_exp),
    .s_wd_rst_en(s_wd_rst_en), .rel_req(rel_req), .clr_we(clr_we), .clr_mask(clr_mask),
    .p_rst_n(p_rst_n), .s_rst_n(s_rst_n), .sec_nmi(sec_nmi), .cause(cause));

  // inputs {pwd,pnmi,swd,snmi,pen,sen,rel,clr,mask[3:0]} | idle cycles | expect {p,s,nmi,cause[3:0]}
  localparam int NV = 27;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {12'b000000100000, 5'd0,  7'b1100000},  // R7 release after boot
    {12'b001000000000, 5'd0,  7'b1100000},  // R6 secondary WD without enable ignored
    {12'b001001000000, 5'd0,  7'b1000100},  // R6 secondary WD reset
    {12'b000000000000, 5'd14, 7'b1000100},  // R6 still low at cycle 16 of pulse
    {12'b000000000000, 5'd0,  7'b1100100},  // R8 R5 returns, no NMI
    {12'b000000100000, 5'd0,  7'b1100100},  // R9 release while running
    {12'b000100000000, 5'd0,  7'b1001100},  // R4 secondary NMIWD
    {12'b000000000000, 5'd14, 7'b1001100},  // R4 still low
    {12'b000000000000, 5'd0,  7'b1111100},  // R5 NMI on exit
    {12'b000000000000, 5'd0,  7'b1101100},  // R5 NMI one cycle
    {12'b000000010100, 5'd0,  7'b1101000},  // R10 clear bit 2
    {12'b100000000000, 5'd0,  7'b1101000},  // R2 primary WD without enable ignored
    {12'b100010000000, 5'd0,  7'b0001001},  // R2 device reset
    {12'b000000100000, 5'd0,  7'b0001001},  // R9 release during device reset
    {12'b000000000000, 5'd13, 7'b0001001},  // R2 still low
    {12'b000000000000, 5'd0,  7'b1001001},  // R2 R7 R10 device back, secondary held
    {12'b000000000000, 5'd5,  7'b1001001},  // R7 still held
    {12'b000000100000, 5'd0,  7'b1101001},  // R7 release
    {12'b000000011111, 5'd0,  7'b1100000},  // R10 clear all
    {12'b010100000000, 5'd0,  7'b0000010},  // R3 R11 primary wins
    {12'b000000000000, 5'd14, 7'b0000010},  // R3 still low
    {12'b000000000000, 5'd0,  7'b1000010},  // R3 R7 device back
    {12'b000000100000, 5'd0,  7'b1100010},  // R7 release
    {12'b000100011000, 5'd0,  7'b1001010},  // R10 set beats clear
    {12'b001001000000, 5'd0,  7'b1001010},  // R11 fault during secondary reset ignored
    {12'b000000000000, 5'd14, 7'b1111010},  // R4 R5 exit with NMI
    {12'b000000000000, 5'd0,  7'b1101010}   // R5 NMI drops
  };

  task automatic drive(input logic [11:0] v);
    {p_wd_exp, p_nmiwd_exp, s_wd_exp, s_nmiwd_exp, p_wd_rst_en, s_wd_rst_en,
     rel_req, clr_we, clr_mask} = v;
  endtask

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {p_rst_n, s_rst_n, sec_nmi, cause};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {p,s,nmi,cause}=%b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    por_n = 1'b0;
    drive(12'b0);
    repeat (3) @(posedge clk);
    #1 check("R1 reset state", 7'b0000000);
    @(negedge clk) por_n = 1'b1;
    @(posedge clk); #1 check("R1 first edge", 7'b0000000);
    @(posedge clk); #1 check("R1 second edge", 7'b1000000);
    repeat (2) @(posedge clk);
    #1 check("R7 held after boot", 7'b1000000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) drive(VEC[i][23:12]);
      @(posedge clk); #1;
      if (VEC[i][11:7] != 0) begin
        @(negedge clk) drive(12'b0);
        repeat (int'(VEC[i][11:7])) @(posedge clk);
        #1;
      end
      check($sformatf("R vector %0d", i), VEC[i][6:0]);
    end

    @(negedge clk) drive(12'b0);
    #2 por_n = 1'b0;
    #1 check("R1 async assert clears flags", 7'b0000000);
    @(negedge clk) por_n = 1'b1;
    @(posedge clk); #1 check("R1 sync first edge", 7'b0000000);
    @(posedge clk); #1 check("R1 R7 sync second edge", 7'b1000000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule